// File: doc/BRIEF.md
# Register-Window Bus Bridge Engine

This block gives a host access to a 32-bit internal peripheral address space through four 64-bit registers. Only full-width accesses are accepted. Bits [4:3] of the host address select a register, so the window repeats across the host address range. A write to the control register launches exactly one transfer on a simple internal request/acknowledge bus. The control word carries a direction flag, a 4-bit size code and a 32-bit target address. The transfer is a read or a write. Write data comes from a separate 32-bit data register.

When the transfer finishes, the engine records a completion flag in a status register. On a read it also records the returned data. Bytes travel most-significant first: internal bus byte lane 0 (bits [7:0]) carries the most significant byte of the host-side value, in both directions. Reading the status register returns its value and then clears it.

A failed read completes with all-ones data. A failure is an error response, or 64 cycles of request without acknowledge. A write reports completion whatever the outcome. While a transfer is in flight, the block reports busy and drops any further control writes.

Top module: `rwb_top`

## Requirements
- R1: The register index is host_addr[4:3]: 0 is control, 1 is reset, 2 is status and 3 is data. All other address bits are ignored.
- R2: An access is accepted only when host_valid is high and all eight bits of host_be are set. Any other access has no effect on any register and produces no read response.
- R3: An accepted read raises host_rvalid for one cycle, on the clock edge after the request, with the value in host_rdata. Control and reset registers read as zero. The data register reads as {data, 32'h0}.
- R4: An accepted write to the data register stores host_wdata[63:32].
- R5: An accepted control write while idle raises bus_req and busy on the next edge. At the same edge the engine sets bus_we = NOT host_wdata[48], bus_size = host_wdata[59:56] and bus_addr = host_wdata[31:0]. These bus signals hold steady until the transfer ends.
- R6: Byte order: bus_wdata[7:0] = data[31:24], bus_wdata[15:8] = data[23:16], and so on. On reads, status[57:50] takes bus_rdata[7:0] and status[33:26] takes bus_rdata[31:24].
- R7: On the edge where bus_ack is sampled with bus_err low, bus_req and busy fall. Status then becomes bit 11 (done) plus, for a read, the byte-ordered data in bits [57:26]. For a write, status is bit 11 only.
- R8: bus_err high, or 64 request cycles without acknowledge, ends the transfer. A failed read reports done with all-ones in bits [57:26]. A failed write reports done only.
- R9: Reading the status register returns its value and then clears it to zero. Writes to the status register are ignored, and writes to the reset register have no effect.
- R10: A control write while busy is dropped: no second transfer starts.
- R11: After reset, busy, bus_req and host_rvalid are low, and status and data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_be | input | 8 | Host byte enables; must be all ones |
| host_addr | input | HOST_AW | Host address; bits [4:3] select the register |
| host_wdata | input | 64 | Host write data |
| host_rvalid | output | 1 | Read response valid |
| host_rdata | output | 64 | Read response data |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus write |
| bus_addr | output | BUS_AW | Internal bus address |
| bus_size | output | 4 | Transfer size code |
| bus_wdata | output | BUS_DW | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_err | input | 1 | Internal bus error |
| bus_rdata | input | BUS_DW | Internal bus read data |
| busy | output | 1 | Transfer in flight |

## Verification
The bench tries reads and writes against a responder with zero and multi-cycle latency, to tell apart the launch timing from the completion timing. An error response and a silent responder separate the two failure paths, and show that only reads carry the all-ones fill. Asymmetric byte patterns in both directions expose any lane reversal mistake. Partial byte enables, aliased address bits, control writes during a transfer, and writes to status and reset show that dropped or ignored accesses leave every visible register untouched.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int WORD_W        = 64;
  localparam int BE_W          = WORD_W / 8;
  localparam int SZ_W          = 4;
  localparam int CTL_RD_BIT    = 48;
  localparam int CTL_SZ_LSB    = 56;
  localparam int STAT_DONE_BIT = 11;
  localparam int STAT_DAT_LSB  = 26;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_RST  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_idx_t;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xs_t;
endpackage

// File: rtl/rwb_decode.sv
module rwb_decode
  import rwb_pkg::*;
(
  input  logic            host_valid,
  input  logic            host_we,
  input  logic [BE_W-1:0] host_be,
  input  logic [1:0]      sel_bits,
  output logic            acc_wr,
  output logic            acc_rd,
  output reg_idx_t        idx
);
  logic accepted;

  assign accepted = host_valid && (&host_be);
  assign acc_wr   = accepted && host_we;
  assign acc_rd   = accepted && !host_we;
  assign idx      = reg_idx_t'(sel_bits);
endmodule

// File: rtl/rwb_byteswap.sv
module rwb_byteswap #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign dout[8*k +: 8] = din[8*(BYTES-1-k) +: 8];
  end
endmodule

// File: rtl/rwb_xact.sv
module rwb_xact
  import rwb_pkg::*;
#(
  parameter int BUS_AW  = 32,
  parameter int BUS_DW  = 32,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_rd,
  input  logic [BUS_AW-1:0] launch_addr,
  input  logic [SZ_W-1:0]   launch_size,
  input  logic [BUS_DW-1:0] launch_wdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [SZ_W-1:0]   bus_size,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              busy,
  output logic              done,
  output logic              done_ok,
  output logic              done_rd
);
  localparam int TW = $clog2(TIMEOUT + 1);

  xs_t           state;
  logic [TW-1:0] tmr;
  logic          expire;

  assign busy    = (state == XS_WAIT);
  assign expire  = (tmr == TW'(TIMEOUT - 1));
  assign done    = busy && (bus_ack || bus_err || expire);
  assign done_ok = bus_ack && !bus_err;
  assign done_rd = !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
      tmr       <= '0;
    end else begin
      case (state)
        XS_IDLE: begin
          if (launch) begin
            state     <= XS_WAIT;
            bus_req   <= 1'b1;
            bus_we    <= !launch_rd;
            bus_addr  <= launch_addr;
            bus_size  <= launch_size;
            bus_wdata <= launch_wdata;
            tmr       <= '0;
          end
        end
        XS_WAIT: begin
          if (done) begin
            state   <= XS_IDLE;
            bus_req <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rwb_top.sv
module rwb_top
  import rwb_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int BUS_AW  = 32,
  parameter int BUS_DW  = 32,
  parameter int TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_valid,
  input  logic               host_we,
  input  logic [7:0]         host_be,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic               host_rvalid,
  output logic [63:0]        host_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BUS_AW-1:0]  bus_addr,
  output logic [3:0]         bus_size,
  output logic [BUS_DW-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic               bus_err,
  input  logic [BUS_DW-1:0]  bus_rdata,
  output logic               busy
);
  localparam int NBYTES = BUS_DW / 8;

  logic              acc_wr, acc_rd;
  reg_idx_t          idx;
  logic [BUS_DW-1:0] data_q;
  logic [63:0]       stat_q;
  logic [BUS_DW-1:0] data_swapped, rd_swapped;
  logic              launch, done, done_ok, done_rd;
  logic [63:0]       stat_new;

  rwb_decode u_dec (
    .host_valid (host_valid),
    .host_we    (host_we),
    .host_be    (host_be),
    .sel_bits   (host_addr[4:3]),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .idx        (idx)
  );

  rwb_byteswap #(.BYTES(NBYTES)) u_wswap (.din(data_q),    .dout(data_swapped));
  rwb_byteswap #(.BYTES(NBYTES)) u_rswap (.din(bus_rdata), .dout(rd_swapped));

  assign launch = acc_wr && (idx == REG_CTRL) && !busy;

  rwb_xact #(
    .BUS_AW  (BUS_AW),
    .BUS_DW  (BUS_DW),
    .TIMEOUT (TIMEOUT)
  ) u_xact (
    .clk          (clk),
    .rst          (rst),
    .launch       (launch),
    .launch_rd    (host_wdata[CTL_RD_BIT]),
    .launch_addr  (host_wdata[BUS_AW-1:0]),
    .launch_size  (host_wdata[CTL_SZ_LSB +: SZ_W]),
    .launch_wdata (data_swapped),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack),
    .bus_err      (bus_err),
    .busy         (busy),
    .done         (done),
    .done_ok      (done_ok),
    .done_rd      (done_rd)
  );

  always_comb begin
    stat_new                = '0;
    stat_new[STAT_DONE_BIT] = 1'b1;
    if (done_rd) begin
      stat_new[STAT_DAT_LSB +: BUS_DW] = done_ok ? rd_swapped : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q      <= '0;
      stat_q      <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      if (acc_wr && idx == REG_DATA) begin
        data_q <= host_wdata[63 -: BUS_DW];
      end
      if (done) begin
        stat_q <= stat_new;
      end else if (acc_rd && idx == REG_STAT) begin
        stat_q <= '0;
      end
      host_rvalid <= acc_rd;
      if (acc_rd) begin
        case (idx)
          REG_STAT: host_rdata <= stat_q;
          REG_DATA: host_rdata <= {data_q, {(64-BUS_DW){1'b0}}};
          default:  host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
  parameter int HOST_AW = 8,
  parameter int BUS_AW  = 32,
  parameter int BUS_DW  = 32,
  parameter int TIMEOUT = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               host_valid,
  input logic               host_we,
  input logic [7:0]         host_be,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_rvalid,
  input logic               bus_req,
  input logic               bus_we,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [BUS_DW-1:0]  bus_wdata,
  input logic               bus_ack,
  input logic               bus_err,
  input logic               busy,
  input logic [63:0]        stat_q
);
  localparam int CW = $clog2(TIMEOUT + 2);

  logic [CW-1:0] wait_cnt;
  logic          rd_acc, stat_rd, finishing;

  assign rd_acc    = host_valid && !host_we && (host_be == 8'hff);
  assign stat_rd   = rd_acc && (host_addr[4:3] == 2'd2);
  assign finishing = bus_req && (bus_ack || bus_err);

  always_ff @(posedge clk) begin
    if (rst || !bus_req || bus_ack || bus_err) wait_cnt <= '0;
    else                                        wait_cnt <= wait_cnt + 1'b1;
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) rd_acc |=> host_rvalid); // R3
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst) !rd_acc |=> !host_rvalid); // R2
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !bus_err) |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we))); // R5
  AST_END_ON_RESP: assert property (@(posedge clk) disable iff (rst) finishing |=> (!bus_req && !busy)); // R7
  AST_DONE_RECORDED: assert property (@(posedge clk) disable iff (rst) finishing |=> stat_q[11]); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst) bus_req |-> (wait_cnt < CW'(TIMEOUT))); // R8
  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst) (stat_rd && !finishing) |=> (stat_q == 64'h0)); // R9
endmodule

bind rwb_top rwb_checker #(
  .HOST_AW (HOST_AW),
  .BUS_AW  (BUS_AW),
  .BUS_DW  (BUS_DW),
  .TIMEOUT (TIMEOUT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_valid  (host_valid),
  .host_we     (host_we),
  .host_be     (host_be),
  .host_addr   (host_addr),
  .host_rvalid (host_rvalid),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ack     (bus_ack),
  .bus_err     (bus_err),
  .busy        (busy),
  .stat_q      (stat_q)
);

// File: tb/rwb_top_tb_top.sv
module rwb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0, host_we = 1'b0;
  logic [7:0]  host_be = 8'h00;
  logic [7:0]  host_addr = 8'h00;
  logic [63:0] host_wdata = 64'h0;
  logic        host_rvalid;
  logic [63:0] host_rdata;
  logic        bus_req, bus_we, busy;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_size;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = 32'h0;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwb_top #(.HOST_AW(8), .BUS_AW(32), .BUS_DW(32), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_we(host_we), .host_be(host_be),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .busy(busy));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = v[8*(3-b) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] stat_of(input bit is_rd, input logic [31:0] d);
    logic [63:0] s = 64'h800;
    if (is_rd) s = s | (64'(d) << 26);
    return s;
  endfunction

  // Bus responder
  int          rsp_lat = 0;
  bit          rsp_err = 0, rsp_mute = 0;
  logic [31:0] rsp_data = 32'h0;
  int          rcnt = 0;
  always @(negedge clk) begin
    if (rst || !bus_req) begin
      rcnt = 0; bus_ack <= 1'b0; bus_err <= 1'b0;
    end else begin
      if (!rsp_mute && rcnt == rsp_lat) begin
        bus_ack <= !rsp_err; bus_err <= rsp_err; bus_rdata <= rsp_data;
      end else begin
        bus_ack <= 1'b0; bus_err <= 1'b0;
      end
      rcnt++;
    end
  end

  // Behavioural reference model
  bit          m_busy, m_req, m_we, m_rvalid;
  logic [31:0] m_addr, m_wdata, m_data;
  logic [3:0]  m_size;
  logic [63:0] m_stat, m_rdata;
  int          m_tmr;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_req = 0; m_we = 0; m_rvalid = 0; m_addr = 0; m_wdata = 0;
      m_data = 0; m_size = 0; m_stat = 0; m_rdata = 0; m_tmr = 0;
    end else begin
      bit acc, fin, was_busy;
      int ix;
      logic [63:0] old_stat, nstat;
      logic [31:0] old_data;
      acc = host_valid && host_be == 8'hff;
      ix = (int'(host_addr) >> 3) & 3;
      was_busy = m_busy; old_stat = m_stat; old_data = m_data;
      fin = m_busy && (bus_ack || bus_err || m_tmr == TMO-1);
      nstat = m_stat;
      if (acc && !host_we && ix == 2) nstat = 0;
      if (fin) begin
        nstat = stat_of(!m_we, (bus_ack && !bus_err) ? rev32(bus_rdata) : 32'hffff_ffff);
        m_busy = 0; m_req = 0;
      end else if (m_busy) m_tmr++;
      m_rvalid = acc && !host_we;
      if (m_rvalid) m_rdata = (ix == 2) ? old_stat : (ix == 3) ? {old_data, 32'h0} : 64'h0;
      if (acc && host_we && ix == 3) m_data = host_wdata[63:32];
      if (acc && host_we && ix == 0 && !was_busy) begin
        m_busy = 1; m_req = 1; m_we = !host_wdata[48]; m_addr = host_wdata[31:0];
        m_size = host_wdata[59:56]; m_wdata = rev32(old_data); m_tmr = 0;
      end
      m_stat = nstat;
    end
  end

  int reqcyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req) reqcyc++;
      chk(busy == m_busy, "R5 R7 busy vs model", 64'(busy), 64'(m_busy));
      chk(bus_req == m_req, "R5 R10 bus_req vs model", 64'(bus_req), 64'(m_req));
      chk(host_rvalid == m_rvalid, "R2 R3 rvalid vs model", 64'(host_rvalid), 64'(m_rvalid));
      if (m_rvalid) chk(host_rdata == m_rdata, "R3 R9 rdata vs model", host_rdata, m_rdata);
      if (m_req) begin
        chk(bus_addr == m_addr && bus_we == m_we && bus_size == m_size,
            "R5 bus fields vs model", {bus_we, bus_size, bus_addr}, {m_we, m_size, m_addr});
        chk(bus_wdata == m_wdata, "R6 bus_wdata vs model", 64'(bus_wdata), 64'(m_wdata));
      end
    end
  end

  task automatic hwrite(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be = 8'hff);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_addr = a; host_wdata = d; host_be = be;
    @(negedge clk);
    host_valid = 0; host_we = 0; host_be = 0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [63:0] v, output bit got,
                       input logic [7:0] be = 8'hff);
    @(negedge clk);
    host_valid = 1; host_we = 0; host_addr = a; host_be = be;
    @(negedge clk);
    host_valid = 0; host_be = 0;
    got = host_rvalid; v = host_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [63:0] ctl(input bit rd, input logic [3:0] sz, input logic [31:0] a);
    return (64'(rd) << 48) | (64'(sz) << 56) | 64'(a);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    bit got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !bus_req && !host_rvalid, "R11 idle after reset", {busy, bus_req, host_rvalid}, 0);
    hread(8'h10, v, got);
    chk(got && v == 0, "R11 status zero after reset", v, 0);

    // data register
    hwrite(8'h18, 64'hA1B2C3D4_5566_7788);
    hread(8'h18, v, got);
    chk(got && v == 64'hA1B2C3D4_0000_0000, "R4 data readback", v, 64'hA1B2C3D4_0000_0000);
    hread(8'h00, v, got);
    chk(got && v == 0, "R3 control reads zero", v, 0);
    hread(8'h08, v, got);
    chk(got && v == 0, "R3 reset reads zero", v, 0);

    // write transfer
    rsp_lat = 2; rsp_err = 0;
    hwrite(8'h00, ctl(0, 4'h4, 32'h1234_5678));
    chk(bus_req && busy && bus_we, "R5 launch write", {bus_req, busy, bus_we}, 3'b111);
    chk(bus_addr == 32'h1234_5678 && bus_size == 4'h4, "R5 address and size",
        {bus_size, bus_addr}, {4'h4, 32'h1234_5678});
    chk(bus_wdata == 32'hD4C3B2A1, "R6 write lane order", 64'(bus_wdata), 64'hD4C3B2A1);
    wait_idle();
    hread(8'h10, v, got);
    chk(v == 64'h800, "R7 write done status", v, 64'h800);
    hread(8'h10, v, got);
    chk(v == 0, "R9 status cleared by read", v, 0);

    // read transfer, zero latency
    rsp_lat = 0; rsp_data = 32'h1122_3344;
    hwrite(8'h00, ctl(1, 4'h2, 32'h0000_0040));
    chk(!bus_we, "R5 read direction", 64'(bus_we), 0);
    wait_idle();
    hread(8'h10, v, got);
    chk(v == stat_of(1, 32'h4433_2211), "R6 R7 read data order", v, stat_of(1, 32'h4433_2211));

    // read with error
    rsp_err = 1; rsp_lat = 1;
    hwrite(8'h00, ctl(1, 4'h1, 32'h0000_0080));
    wait_idle();
    hread(8'h10, v, got);
    chk(v == stat_of(1, 32'hffff_ffff), "R8 read error fill", v, stat_of(1, 32'hffff_ffff));

    // write with error
    hwrite(8'h00, ctl(0, 4'h1, 32'h0000_0084));
    wait_idle();
    hread(8'h10, v, got);
    chk(v == 64'h800, "R8 write error reports done only", v, 64'h800);
    rsp_err = 0;

    // read with timeout
    rsp_mute = 1; reqcyc = 0;
    hwrite(8'h00, ctl(1, 4'h4, 32'h0000_0100));
    wait_idle();
    chk(reqcyc == TMO, "R8 timeout length", 64'(reqcyc), 64'(TMO));
    hread(8'h10, v, got);
    chk(v == stat_of(1, 32'hffff_ffff), "R8 timeout fill", v, stat_of(1, 32'hffff_ffff));
    rsp_mute = 0;

    // control write while busy is dropped
    rsp_lat = 10; rsp_data = 32'hCAFE_F00D;
    hwrite(8'h00, ctl(1, 4'h4, 32'h0000_0200));
    hwrite(8'h00, ctl(0, 4'h4, 32'h0000_0300));
    chk(bus_addr == 32'h0000_0200 && !bus_we, "R10 first transfer kept", 64'(bus_addr), 64'h200);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(!bus_req && !busy, "R10 no second transfer", {bus_req, busy}, 0);
    hread(8'h10, v, got);
    chk(v == stat_of(1, 32'h0DF0_FECA), "R10 status from first", v, stat_of(1, 32'h0DF0_FECA));

    // status and reset writes ignored
    rsp_lat = 0;
    hwrite(8'h00, ctl(0, 4'h4, 32'h0000_0400));
    wait_idle();
    hwrite(8'h10, 64'h0);
    hwrite(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    hread(8'h10, v, got);
    chk(v == 64'h800, "R9 status write ignored", v, 64'h800);
    hread(8'h18, v, got);
    chk(v == 64'hA1B2C3D4_0000_0000, "R9 reset write no effect", v, 64'hA1B2C3D4_0000_0000);
    chk(!busy, "R9 reset write starts nothing", 64'(busy), 0);

    // partial access
    hwrite(8'h18, 64'h0BAD_0BAD_0000_0000, 8'h0f);
    hread(8'h18, v, got);
    chk(v == 64'hA1B2C3D4_0000_0000, "R2 partial write ignored", v, 64'hA1B2C3D4_0000_0000);
    hread(8'h18, v, got, 8'hf0);
    chk(!got, "R2 partial read no response", 64'(got), 0);

    // decode alias
    hwrite(8'hE5 & 8'hFD | 8'h18, 64'h1357_9BDF_0000_0000);
    hread(8'h39, v, got);
    chk(got && v == 64'h1357_9BDF_0000_0000, "R1 upper address bits ignored", v, 64'h1357_9BDF_0000_0000);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule